// File: doc/BRIEF.md
# Configuration Bitstream Descrambler and Pin-Toggle Serializer

This block takes a scrambled FPGA configuration image one byte at a time and turns it into the byte sequence that drives a bit-banged serial configuration port. Each incoming byte is XORed with one byte of a keystream. The keystream comes from a 32-bit recurrence. After the XOR, every bit of the recovered byte becomes two pin-state bytes. The first byte raises the configuration clock pin and the second lowers it, and the data pin carries the bit in both.

The keystream update contains a remainder by a small constant. A multi-cycle restoring divider computes that remainder, so the input side is held off until the next keystream byte is ready and the serializer has emptied. The output side follows valid/ready flow control and tolerates any backpressure pattern. A start pulse begins a new image: it reseeds the keystream, drops any partly sent byte and clears the completion flag. The producer tags the final byte of an image, and the completion flag rises once that byte's last pin-state byte has been taken.

Top module: `bitstream_toggler`

## Requirements
- R1: While reset is low, and on the cycle after, `out_valid`, `done` and `in_ready` are all 0. After reset the keystream state is 0x3F6DF2AB.
- R2: Before each accepted input byte, the 32-bit state s is replaced by ((s + 0x0A853753) mod 177) + s × 0x08034052, with all arithmetic modulo 2^32.
- R3: The recovered byte is the input byte XOR the low 8 bits of the updated state.
- R4: The recovered byte is serialized most significant bit first.
- R5: Each bit yields two output bytes. The first has bit 0 = 1 (clock high) and the second has bit 0 = 0 (clock low).
- R6: The data bit sits at bit 6 of both output bytes. Every other bit of a valid output byte is 0.
- R7: Exactly 16 output bytes leave for each accepted input byte, with none lost, repeated or added.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R9: `in_ready` is 0 while the next keystream byte is not yet computed, while the serializer still holds bits, and on the cycle after a start pulse. An input byte is accepted only when no output byte is pending.
- R10: A start pulse reseeds the state to 0x3F6DF2AB, discards pending output and clears `done`.
- R11: `done` rises on the cycle after the last output byte of an input byte tagged by `in_last` is accepted. It stays high until the next start pulse and is not raised by untagged bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new image |
| in_valid | input | 1 | Input byte available |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Scrambled image byte |
| in_last | input | 1 | Marks the final byte of the image |
| out_valid | output | 1 | Pin-state byte available |
| out_ready | input | 1 | Consumer takes the pin-state byte |
| out_data | output | 8 | Pin-state byte: bit 0 clock, bit 6 data |
| done | output | 1 | Final byte of the image fully emitted |

## Verification
A sweep pushes every one of the 256 byte values through one image under pseudo-random backpressure, and a bench-side 32-bit model predicts each of the 4096 output bytes. A divider with the wrong remainder, a state updated after the XOR instead of before, or a keystream that starts one step late would garble nearly every byte. The bench stalls the output for long stretches. A serializer that advanced while stalled would drop pin bytes, and one that failed to advance would repeat them. A short untagged image followed by a mid-stream start pulse checks two further faults: a design that missed the reseed would continue the old keystream, and a design that raised completion on every byte would show `done` early.

// File: rtl/tgl_pkg.sv
// Package: shared constants and types for the bitstream toggler.
// Assumes a 32-bit keystream state and byte-wide data paths.
package tgl_pkg;
    localparam int          KS_W         = 32;
    localparam int          BYTE_W       = 8;
    localparam logic [31:0] KS_SEED_DEF  = 32'h3F6DF2AB;
    localparam logic [31:0] KS_ADD_DEF   = 32'h0A853753;
    localparam logic [31:0] KS_MUL_DEF   = 32'h08034052;
    localparam int          KS_MOD_DEF   = 177;

    typedef enum logic [1:0] {
        KS_LAUNCH,
        KS_WAIT,
        KS_HOLD
    } ks_phase_t;
endpackage

// File: rtl/tgl_rem_div.sv
// Module: restoring shift-subtract remainder unit.
// Computes dividend mod DIV over W cycles after a one-cycle go pulse and
// raises fin for one cycle when rem is valid. A new go aborts any run.
module tgl_rem_div #(
    parameter int W   = 32,
    parameter int DIV = 177
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               go,
    input  logic [W-1:0]                       dividend,
    output logic                               fin,
    output logic [((DIV > 1) ? $clog2(DIV) : 1)-1:0] rem
);
    localparam int RW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int RW1 = RW + 1;
    localparam int CW  = $clog2(W);
    localparam logic [RW:0] DIV_V = RW1'(DIV);

    logic [W-1:0]  dvd;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [RW:0]   trial;
    logic [RW:0]   rem_nx;

    // One restoring step: bring in the next dividend bit, subtract if it fits.
    always_comb begin
        trial  = {rem, dvd[W-1]};
        rem_nx = (trial >= DIV_V) ? (trial - DIV_V) : trial;
    end

    // Step sequencer: load on go, iterate W times, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            fin  <= 1'b0;
            rem  <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                dvd  <= dividend;
                cnt  <= '0;
                busy <= 1'b1;
                rem  <= '0;
            end else if (busy) begin
                rem <= rem_nx[RW-1:0];
                dvd <= dvd << 1;
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tgl_keystream.sv
// Module: keystream generator.
// Holds the 32-bit state, advances it with the add/mod/multiply recurrence
// and presents the low byte once the update is complete. Assumes take is
// only asserted while key_rdy is high.
module tgl_keystream
    import tgl_pkg::*;
#(
    parameter logic [31:0] SEED = KS_SEED_DEF,
    parameter logic [31:0] ADDK = KS_ADD_DEF,
    parameter logic [31:0] MULK = KS_MUL_DEF,
    parameter int          MODK = KS_MOD_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reseed,
    input  logic              take,
    output logic              key_rdy,
    output logic [BYTE_W-1:0] key
);
    localparam int RW = (MODK > 1) ? $clog2(MODK) : 1;

    logic [KS_W-1:0] st;
    logic [KS_W-1:0] st_nx;
    ks_phase_t       ph;
    logic            div_go;
    logic            div_fin;
    logic [RW-1:0]   div_rem;

    assign div_go  = (ph == KS_LAUNCH) && !reseed;
    assign key_rdy = (ph == KS_HOLD);
    assign key     = st[BYTE_W-1:0];

    tgl_rem_div #(.W(KS_W), .DIV(MODK)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (st + ADDK),
        .fin      (div_fin),
        .rem      (div_rem)
    );

    // Combine the remainder with the wrapped product to form the next state.
    always_comb begin
        st_nx = {{(KS_W - RW){1'b0}}, div_rem} + st * MULK;
    end

    // Phase control: launch divider, wait, hold key until consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SEED;
            ph <= KS_LAUNCH;
        end else if (reseed) begin
            st <= SEED;
            ph <= KS_LAUNCH;
        end else begin
            case (ph)
                KS_LAUNCH: ph <= KS_WAIT;
                KS_WAIT: if (div_fin) begin
                    st <= st_nx;
                    ph <= KS_HOLD;
                end
                KS_HOLD: if (take) ph <= KS_LAUNCH;
                default: ph <= KS_LAUNCH;
            endcase
        end
    end
endmodule

// File: rtl/tgl_bitbang.sv
// Module: bit-to-pin-toggle serializer.
// Loads one byte and emits two pin-state bytes per bit, MSB first: clock
// high then clock low, data on a fixed pin. Assumes load only when idle.
module tgl_bitbang #(
    parameter int DW      = 8,
    parameter int OW      = 8,
    parameter int CLK_POS = 0,
    parameter int DAT_POS = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          load_last,
    output logic          busy,
    output logic [OW-1:0] o_data,
    input  logic          o_ready,
    output logic          done
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0] sh;
    logic [IW-1:0] idx;
    logic          ph_low;
    logic          lastf;

    // Pin pattern for the current bit and phase.
    always_comb begin
        o_data = '0;
        if (busy) begin
            o_data[CLK_POS] = !ph_low;
            o_data[DAT_POS] = sh[DW-1];
        end
    end

    // Bit/phase sequencing with hold under backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            idx    <= '0;
            ph_low <= 1'b0;
            lastf  <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else if (flush) begin
            ph_low <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else if (load) begin
            sh     <= load_byte;
            idx    <= '0;
            ph_low <= 1'b0;
            lastf  <= load_last;
            busy   <= 1'b1;
        end else if (busy && o_ready) begin
            if (!ph_low) begin
                ph_low <= 1'b1;
            end else begin
                ph_low <= 1'b0;
                sh     <= sh << 1;
                idx    <= idx + 1'b1;
                if (idx == IW'(DW - 1)) begin
                    busy <= 1'b0;
                    if (lastf) done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bitstream_toggler.sv
// Module: top of the configuration bitstream descrambler and serializer.
// Accepts scrambled bytes, XORs each with the next keystream byte and hands
// the result to the pin-toggle serializer. Assumes start is a single pulse.
module bitstream_toggler
    import tgl_pkg::*;
#(
    parameter logic [31:0] SEED    = KS_SEED_DEF,
    parameter logic [31:0] ADDK    = KS_ADD_DEF,
    parameter logic [31:0] MULK    = KS_MUL_DEF,
    parameter int          MODK    = KS_MOD_DEF,
    parameter int          CLK_POS = 0,
    parameter int          DAT_POS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       done
);
    logic              key_rdy;
    logic [BYTE_W-1:0] key;
    logic              ser_busy;
    logic              take;

    // Accept only with a fresh key, an empty serializer and no restart.
    assign in_ready  = key_rdy && !ser_busy && !start;
    assign take      = in_valid && in_ready;
    assign out_valid = ser_busy;

    tgl_keystream #(
        .SEED (SEED),
        .ADDK (ADDK),
        .MULK (MULK),
        .MODK (MODK)
    ) u_ks (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (start),
        .take    (take),
        .key_rdy (key_rdy),
        .key     (key)
    );

    tgl_bitbang #(
        .DW      (BYTE_W),
        .OW      (8),
        .CLK_POS (CLK_POS),
        .DAT_POS (DAT_POS)
    ) u_bb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start),
        .load      (take),
        .load_byte (in_data ^ key),
        .load_last (in_last),
        .busy      (ser_busy),
        .o_data    (out_data),
        .o_ready   (out_ready),
        .done      (done)
    );
endmodule

// File: rtl/bitstream_toggler_chk.sv
// Module: protocol checker for bitstream_toggler, attached by bind.
// Observes ports only; assumes the default pin positions (clock 0, data 6).
module bitstream_toggler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       done
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !done && !in_ready)); // R1

    AST_CLK_HIGH_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_data[0] && !start)
        |=> (out_valid && !out_data[0] && out_data[6] == $past(out_data[6]))); // R5

    AST_LOW_THEN_HIGH_OR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_data[0] && !start)
        |=> (!out_valid || out_data[0])); // R5

    AST_PIN_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & 8'hBE) == 8'h00)); // R6

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data))); // R8

    AST_ACCEPT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> !out_valid); // R9

    AST_NO_KEY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> !in_ready); // R9

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !out_valid)); // R10

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready && !out_data[0])); // R11
endmodule

bind bitstream_toggler bitstream_toggler_chk u_chk (.*);

// File: tb/sim_bitstream_toggler.sv
`timescale 1ns/1ps
module sim_bitstream_toggler;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       in_last;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;
    logic       done;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  exp_q [0:8191];
    int          wr_p = 0;
    int          rd_p = 0;
    logic [31:0] ks;
    int          bp_mode = 0;
    logic [15:0] lf = 16'hACE1;
    int          bp_cnt = 0;
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_data = 8'h00;

    always #2.5 clk = ~clk;

    bitstream_toggler u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Keystream recurrence as stated in R2.
    function automatic logic [31:0] ks_next(input logic [31:0] s);
        logic [31:0] a;
        a = s + 32'h0A853753;
        return (a % 32'd177) + s * 32'h08034052;
    endfunction

    // Expected pin bytes for one input byte (R3, R4, R5, R6).
    task automatic model_byte(input logic [7:0] b);
        logic [7:0] d;
        ks = ks_next(ks);
        d  = b ^ ks[7:0];
        for (int bi = 7; bi >= 0; bi--) begin
            exp_q[wr_p] = {1'b0, d[bi], 5'b0, 1'b1};
            exp_q[wr_p + 1] = {1'b0, d[bi], 5'b0, 1'b0};
            wr_p += 2;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic last);
        model_byte(b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        while (!in_ready) @(negedge clk);
        chk(!out_valid, "R9 accept with output pending", {31'b0, out_valid}, 0);
        @(posedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (rd_p != wr_p) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ks = 32'h3F6DF2AB;
        chk(!in_ready, "R9 ready right after start", {31'b0, in_ready}, 0);
        chk(!done, "R10 done cleared by start", {31'b0, done}, 0);
    endtask

    // Output monitor: backpressure generation and byte-by-byte comparison.
    always @(negedge clk) begin
        logic r;
        if (rst_n) begin
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R8 hold under stall",
                    {23'b0, out_valid, out_data}, {24'h000001, prev_data});
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            bp_cnt++;
            case (bp_mode)
                0:       r = 1'b1;
                1:       r = lf[0];
                default: r = (bp_cnt % 7 == 0);
            endcase
            if (out_valid && r) begin
                if (rd_p < wr_p)
                    chk(out_data == exp_q[rd_p], "R2 R3 R4 R5 R6 pin byte",
                        {24'b0, out_data}, {24'b0, exp_q[rd_p]});
                else
                    chk(1'b0, "R7 extra output byte", {24'b0, out_data}, 0);
                rd_p++;
            end
            prev_stall = out_valid && !r;
            prev_data  = out_data;
            out_ready  = r;
        end else begin
            out_ready  = 1'b0;
            prev_stall = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
        repeat (4) @(negedge clk);
        chk(!out_valid, "R1 reset out_valid", {31'b0, out_valid}, 0);
        chk(!done, "R1 reset done", {31'b0, done}, 0);
        chk(!in_ready, "R1 reset in_ready", {31'b0, in_ready}, 0);
        rst_n = 1'b1;
        ks = 32'h3F6DF2AB;

        // R1: first image runs from the reset seed without a start pulse.
        send_byte(8'h00, 1'b0);
        send_byte(8'hFF, 1'b0);
        send_byte(8'hA5, 1'b1);
        drain();
        chk(done, "R11 done after tagged byte", {31'b0, done}, 1);
        chk(rd_p == 48, "R7 sixteen bytes per input", rd_p, 48);

        // R11: untagged bytes must not raise done; R10 reseeds mid-stream.
        pulse_start();
        bp_mode = 1;
        send_byte(8'h3C, 1'b0);
        send_byte(8'h81, 1'b0);
        send_byte(8'h7E, 1'b0);
        drain();
        chk(!done, "R11 no done without tag", {31'b0, done}, 0);
        pulse_start();

        // Sweep of all byte values from a fresh seed under random stalls.
        for (int v = 0; v < 256; v++) send_byte(v[7:0], v == 255);
        drain();
        chk(done, "R11 done after sweep", {31'b0, done}, 1);
        repeat (20) @(negedge clk);
        chk(done, "R11 done stays high", {31'b0, done}, 1);
        chk(!out_valid, "R7 no output after drain", {31'b0, out_valid}, 0);

        // R8: long stalls, one pin byte accepted every seventh cycle.
        pulse_start();
        bp_mode = 2;
        send_byte(8'hC3, 1'b0);
        send_byte(8'h18, 1'b0);
        send_byte(8'hE7, 1'b1);
        drain();
        chk(done, "R11 done after stalled image", {31'b0, done}, 1);
        chk(rd_p == wr_p, "R7 counts match", rd_p, wr_p);
        repeat (10) @(negedge clk);
        chk(!out_valid && rd_p == wr_p, "R7 no trailing bytes", rd_p, wr_p);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule